// File: doc/BRIEF.md
# Control transfer stage sequencer

This block drives one control transfer from start to finish. It uses a chunk-transfer engine that moves one stage's worth of data when asked and returns a completion code. The sequencer issues the setup stage, then an optional data stage, then the status stage. For each stage it sets the packet identifier, the direction, the length and the buffer offset. When the engine answers with the retry code, it issues the same stage again. It totals the bytes moved in the data stage and reports one result when the transfer ends.

A request whose device address matches the root hub's device number never reaches the bus. It goes to a root-hub port through a start/done handshake. The result of that path is flagged as high speed. Each stage counts its own retries, so a device that keeps answering with a retry produces a timeout and does not stall the transfer forever.

Top module: `ctl_seq`

## Requirements
- R1: The setup stage is issued with packet identifier code 3 (setup), direction out (`eng_in_o`=0), length 8 and offset 0.
- R2: The data stage is issued only when `has_data_i` was set at start. It uses identifier code 2 (DATA1) and the direction of `pipe_in_i` (1 = in). On every attempt, the length is the requested total minus the bytes already moved and the offset is the bytes already moved.
- R3: The status stage is issued with identifier code 2 (DATA1) and length 0. Its direction is the opposite of the pipe direction when a data stage ran, and in (`eng_in_o`=1) when no data stage ran.
- R4: An engine completion with code 1 (retry) reissues the same stage. Each stage has its own retry count, which is cleared when a stage is entered. Each attempt is announced by a one-cycle `eng_start_o`.
- R5: In any one stage, the MAX_TRIES-th retry completion ends the transfer with result 2 (timeout) and issues no further attempt.
- R6: An engine completion with code 2 or 3 ends the transfer at once with result 1 (error). No later stage is issued.
- R7: On success (result 0), `act_len_o` is the sum of `eng_moved_i` over all data-stage completions with code 0 or 1. It is 0 when no data stage ran. It is 0 after an error or a timeout.
- R8: When `dev_addr_i` equals `root_addr_i` at start, only `rh_start_o` is pulsed and no engine attempt is made. The result is 1 when `rh_err_i` is set and 0 otherwise. `act_len_o` then carries `rh_len_i` on success, and `high_speed_o` is 1. `high_speed_o` is 0 for bus transfers.
- R9: While `busy_o` is high, `start_i` is ignored, and changes on the request inputs have no effect, since they are captured at the accepted start.
- R10: `done_o` is a one-cycle pulse. `result_o`, `act_len_o` and `high_speed_o` are valid with it and held until the next transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transfer (accepted when idle) |
| dev_addr_i | input | ADDR_W | Target device address |
| root_addr_i | input | ADDR_W | Device number of the root hub |
| pipe_in_i | input | 1 | Pipe direction, 1 = in |
| has_data_i | input | 1 | Transfer has a data stage |
| data_len_i | input | LEN_W | Requested data-stage length in bytes |
| busy_o | output | 1 | Transfer in progress |
| eng_start_o | output | 1 | Pulse: issue one engine attempt |
| eng_pid_o | output | 2 | Packet identifier: 0 DATA0, 2 DATA1, 3 setup |
| eng_in_o | output | 1 | Attempt direction, 1 = in |
| eng_len_o | output | LEN_W | Bytes requested for the attempt |
| eng_off_o | output | LEN_W | Buffer offset for the attempt |
| eng_done_i | input | 1 | Engine attempt complete |
| eng_code_i | input | 2 | 0 ok, 1 retry, 2 or 3 error |
| eng_moved_i | input | LEN_W | Bytes moved by the attempt |
| rh_start_o | output | 1 | Pulse: hand the request to the root-hub port |
| rh_done_i | input | 1 | Root-hub port finished |
| rh_err_i | input | 1 | Root-hub port rejected the request |
| rh_len_i | input | LEN_W | Bytes returned by the root-hub port |
| done_o | output | 1 | Pulse: transfer finished |
| result_o | output | 2 | 0 ok, 1 error, 2 timeout |
| act_len_o | output | LEN_W | Reported actual length |
| high_speed_o | output | 1 | Result came from the root-hub path |

## Verification
The bench sweeps retry counts from zero up to the timeout limit in each stage independently. It does this with and without a data stage, for both pipe directions and for several data lengths. The sweep separates per-stage counting from a shared count and catches wrong status-stage directions. Partial moves on retries, taken in chunks smaller than the remaining length, show whether the length and offset advance by the bytes actually moved. Errors injected into each stage show an immediate abort. The root-hub cases, and cases where request inputs change and start is pulsed mid-transfer, show that the bus is bypassed and that the request is captured only at the accepted start.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DATA, ST_STATUS, ST_ROOT, ST_FIN
  } stage_e;

  localparam logic [1:0] PID_DATA0 = 2'd0;
  localparam logic [1:0] PID_DATA1 = 2'd2;
  localparam logic [1:0] PID_SETUP = 2'd3;

  localparam logic [1:0] CODE_OK    = 2'd0;
  localparam logic [1:0] CODE_RETRY = 2'd1;

  localparam logic [1:0] RES_OK  = 2'd0;
  localparam logic [1:0] RES_ERR = 2'd1;
  localparam logic [1:0] RES_TMO = 2'd2;

  localparam int SETUP_BYTES = 8;
endpackage

// File: rtl/ctl_seq_retry.sv
module ctl_seq_retry #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_TRIES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(MAX_TRIES - 1));

  // R5: count never passes the limit
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_TRIES));
  // R4: clearing and counting never requested together
  a_r4_clr_inc_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && inc_i));
endmodule

// File: rtl/ctl_seq_bytes.sv
module ctl_seq_bytes #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] moved_i,
  input  logic [LEN_W-1:0] total_i,
  output logic [LEN_W-1:0] acc_o,
  output logic [LEN_W-1:0] rem_o
);
  logic [LEN_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= acc_q + moved_i;
  end

  assign acc_o = acc_q;
  assign rem_o = (total_i > acc_q) ? total_i - acc_q : '0;

  // R7: byte total only grows within a transfer
  a_r7_acc_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
  import ctl_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       to_root_i,
  input  logic       has_data_i,
  input  logic       eng_done_i,
  input  logic [1:0] eng_code_i,
  input  logic       rh_done_i,
  input  logic       rh_err_i,
  input  logic       last_try_i,
  output stage_e     stage_o,
  output logic       issue_o,
  output logic       cap_o,
  output logic       retry_clr_o,
  output logic       retry_inc_o,
  output logic       acc_clr_o,
  output logic       acc_add_o,
  output logic       fin_o,
  output logic [1:0] fin_res_o,
  output logic       done_o,
  output logic       busy_o
);
  stage_e stage_q, stage_d;
  logic   issue_q, issue_d;

  always_comb begin
    stage_d     = stage_q;
    issue_d     = 1'b0;
    cap_o       = 1'b0;
    retry_clr_o = 1'b0;
    retry_inc_o = 1'b0;
    acc_clr_o   = 1'b0;
    acc_add_o   = 1'b0;
    fin_o       = 1'b0;
    fin_res_o   = RES_OK;
    case (stage_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_o       = 1'b1;
          acc_clr_o   = 1'b1;
          retry_clr_o = 1'b1;
          issue_d     = 1'b1;
          stage_d     = to_root_i ? ST_ROOT : ST_SETUP;
        end
      end
      ST_SETUP, ST_DATA, ST_STATUS: begin
        if (!issue_q && eng_done_i) begin
          if (eng_code_i == CODE_OK) begin
            acc_add_o   = (stage_q == ST_DATA);
            retry_clr_o = 1'b1;
            if (stage_q == ST_STATUS) begin
              fin_o = 1'b1;
            end else begin
              issue_d = 1'b1;
              stage_d = (stage_q == ST_SETUP && has_data_i) ? ST_DATA : ST_STATUS;
            end
          end else if (eng_code_i == CODE_RETRY) begin
            acc_add_o = (stage_q == ST_DATA);
            if (last_try_i) begin
              fin_o     = 1'b1;
              fin_res_o = RES_TMO;
            end else begin
              retry_inc_o = 1'b1;
              issue_d     = 1'b1;
            end
          end else begin
            fin_o     = 1'b1;
            fin_res_o = RES_ERR;
          end
        end
      end
      ST_ROOT: begin
        if (!issue_q && rh_done_i) begin
          fin_o     = 1'b1;
          fin_res_o = rh_err_i ? RES_ERR : RES_OK;
        end
      end
      ST_FIN:  stage_d = ST_IDLE;
      default: stage_d = ST_IDLE;
    endcase
    if (fin_o) stage_d = ST_FIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      issue_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      issue_q <= issue_d;
    end
  end

  assign stage_o = stage_q;
  assign issue_o = issue_q;
  assign done_o  = (stage_q == ST_FIN);
  assign busy_o  = (stage_q != ST_IDLE);

  // R10: completion lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4: every attempt is announced by a single-cycle pulse
  a_r4_issue_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !issue_o);
  // R9: a start while busy does not restart capture
  a_r9_no_recapture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cap_o);
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_seq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int LEN_W     = 16,
  parameter int MAX_TRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [ADDR_W-1:0] root_addr_i,
  input  logic              pipe_in_i,
  input  logic              has_data_i,
  input  logic [LEN_W-1:0]  data_len_i,
  output logic              busy_o,
  output logic              eng_start_o,
  output logic [1:0]        eng_pid_o,
  output logic              eng_in_o,
  output logic [LEN_W-1:0]  eng_len_o,
  output logic [LEN_W-1:0]  eng_off_o,
  input  logic              eng_done_i,
  input  logic [1:0]        eng_code_i,
  input  logic [LEN_W-1:0]  eng_moved_i,
  output logic              rh_start_o,
  input  logic              rh_done_i,
  input  logic              rh_err_i,
  input  logic [LEN_W-1:0]  rh_len_i,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [LEN_W-1:0]  act_len_o,
  output logic              high_speed_o
);
  stage_e           stage;
  logic             issue, cap, retry_clr, retry_inc, acc_clr, acc_add;
  logic             fin, last_try;
  logic [1:0]       fin_res;
  logic [LEN_W-1:0] acc, rem;

  logic             pin_q, hd_q;
  logic [LEN_W-1:0] tot_q;
  logic [1:0]       res_q;
  logic [LEN_W-1:0] len_res_q;
  logic             hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      hd_q  <= 1'b0;
      tot_q <= '0;
    end else if (cap) begin
      pin_q <= pipe_in_i;
      hd_q  <= has_data_i;
      tot_q <= data_len_i;
    end
  end

  ctl_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .to_root_i   (dev_addr_i == root_addr_i),
    .has_data_i  (hd_q),
    .eng_done_i  (eng_done_i),
    .eng_code_i  (eng_code_i),
    .rh_done_i   (rh_done_i),
    .rh_err_i    (rh_err_i),
    .last_try_i  (last_try),
    .stage_o     (stage),
    .issue_o     (issue),
    .cap_o       (cap),
    .retry_clr_o (retry_clr),
    .retry_inc_o (retry_inc),
    .acc_clr_o   (acc_clr),
    .acc_add_o   (acc_add),
    .fin_o       (fin),
    .fin_res_o   (fin_res),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  ctl_seq_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (retry_clr),
    .inc_i  (retry_inc),
    .last_o (last_try)
  );

  ctl_seq_bytes #(.LEN_W(LEN_W)) u_bytes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (acc_clr),
    .add_i   (acc_add),
    .moved_i (eng_moved_i),
    .total_i (tot_q),
    .acc_o   (acc),
    .rem_o   (rem)
  );

  always_comb begin
    eng_pid_o = PID_DATA0;
    eng_in_o  = 1'b0;
    eng_len_o = '0;
    eng_off_o = '0;
    case (stage)
      ST_SETUP: begin
        eng_pid_o = PID_SETUP;
        eng_len_o = LEN_W'(SETUP_BYTES);
      end
      ST_DATA: begin
        eng_pid_o = PID_DATA1;
        eng_in_o  = pin_q;
        eng_len_o = rem;
        eng_off_o = acc;
      end
      ST_STATUS: begin
        eng_pid_o = PID_DATA1;
        eng_in_o  = hd_q ? ~pin_q : 1'b1;
      end
      default: ;
    endcase
  end

  assign eng_start_o = issue && (stage != ST_ROOT);
  assign rh_start_o  = issue && (stage == ST_ROOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= RES_OK;
      len_res_q <= '0;
      hs_q      <= 1'b0;
    end else if (fin) begin
      res_q <= fin_res;
      hs_q  <= (stage == ST_ROOT);
      if (fin_res != RES_OK)    len_res_q <= '0;
      else if (stage == ST_ROOT) len_res_q <= rh_len_i;
      else                       len_res_q <= acc;
    end
  end

  assign result_o     = res_q;
  assign act_len_o    = len_res_q;
  assign high_speed_o = hs_q;

  // R8: bus and root-hub paths never started together
  a_r8_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eng_start_o, rh_start_o}));
  // R10: results only change when a transfer ends
  a_r10_res_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(result_o)));
endmodule

// File: tb/ctl_seq_bench.sv
module ctl_seq_bench;
  localparam int AW = 4;
  localparam int LW = 10;
  localparam int MT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] dev_addr_i = '0;
  logic [AW-1:0] root_addr_i = '0;
  logic          pipe_in_i = 1'b0;
  logic          has_data_i = 1'b0;
  logic [LW-1:0] data_len_i = '0;
  logic          busy_o, eng_start_o, eng_in_o;
  logic [1:0]    eng_pid_o;
  logic [LW-1:0] eng_len_o, eng_off_o;
  logic          eng_done_i = 1'b0;
  logic [1:0]    eng_code_i = '0;
  logic [LW-1:0] eng_moved_i = '0;
  logic          rh_start_o;
  logic          rh_done_i = 1'b0;
  logic          rh_err_i = 1'b0;
  logic [LW-1:0] rh_len_i = '0;
  logic          done_o, high_speed_o;
  logic [1:0]    result_o;
  logic [LW-1:0] act_len_o;

  always #10 clk = ~clk;

  ctl_seq #(.ADDR_W(AW), .LEN_W(LW), .MAX_TRIES(MT)) u_ctl_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .root_addr_i(root_addr_i), .pipe_in_i(pipe_in_i), .has_data_i(has_data_i),
    .data_len_i(data_len_i), .busy_o(busy_o), .eng_start_o(eng_start_o),
    .eng_pid_o(eng_pid_o), .eng_in_o(eng_in_o), .eng_len_o(eng_len_o),
    .eng_off_o(eng_off_o), .eng_done_i(eng_done_i), .eng_code_i(eng_code_i),
    .eng_moved_i(eng_moved_i), .rh_start_o(rh_start_o), .rh_done_i(rh_done_i),
    .rh_err_i(rh_err_i), .rh_len_i(rh_len_i), .done_o(done_o),
    .result_o(result_o), .act_len_o(act_len_o), .high_speed_o(high_speed_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int scr_code [64];
  int scr_mv   [64];
  int exp_w    [64];
  int exp_s    [64];
  int rec_w    [64];
  int n_exp = 0;
  int base_idx = 0;
  int n_rec = 0;
  int n_rh = 0;
  bit rh_err_cfg = 1'b0;
  int rh_len_cfg = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pk(input int pid, input int din, input int len, input int off);
    return (pid << 21) | (din << 20) | (len << 10) | off;
  endfunction

  // engine and root-hub port model: one-cycle latency responses
  initial begin
    forever begin
      @(negedge clk);
      eng_done_i = 1'b0;
      rh_done_i  = 1'b0;
      if (eng_start_o) begin
        int i;
        i = n_rec - base_idx;
        if (i >= 0 && i < 64) rec_w[i] = pk(eng_pid_o, eng_in_o, eng_len_o, eng_off_o);
        n_rec++;
        @(negedge clk);
        eng_done_i  = 1'b1;
        eng_code_i  = (i >= 0 && i < 64) ? 2'(scr_code[i]) : 2'd2;
        eng_moved_i = (i >= 0 && i < 64) ? LW'(scr_mv[i]) : '0;
      end else if (rh_start_o) begin
        n_rh++;
        @(negedge clk);
        rh_done_i = 1'b1;
        rh_err_i  = rh_err_cfg;
        rh_len_i  = LW'(rh_len_cfg);
      end
    end
  end

  task automatic add_att(input int s, input int pid, input int din, input int len,
                         input int off, input int code, input int mv);
    exp_w[n_exp]    = pk(pid, din, len, off);
    exp_s[n_exp]    = s;
    scr_code[n_exp] = code;
    scr_mv[n_exp]   = mv;
    n_exp++;
  endtask

  // expected attempt list and outcome, derived from R1..R7
  task automatic build(input int hd, input int pin, input int tot, input int rs, input int rd,
                       input int rt, input int est, input int chunk,
                       output int eres, output int elen);
    int acc, r, pid, din, len, off, mv;
    bit stop;
    n_exp = 0; acc = 0; eres = 0; stop = 1'b0;
    for (int s = 0; s < 3; s++) begin
      if (stop) break;
      if (s == 1 && hd == 0) continue;
      r   = (s == 0) ? rs : (s == 1) ? rd : rt;
      pid = (s == 0) ? 3 : 2;
      din = (s == 0) ? 0 : (s == 1) ? pin : (hd != 0 ? 1 - pin : 1);
      for (int k = 0; k <= r; k++) begin
        len = (s == 0) ? 8 : (s == 1) ? tot - acc : 0;
        off = (s == 1) ? acc : 0;
        if (k < r) begin
          mv = (s == 1) ? ((chunk < tot - acc) ? chunk : tot - acc) : 0;
          add_att(s, pid, din, len, off, 1, mv);
          acc += mv;
          if (k == MT - 1) begin eres = 2; stop = 1'b1; break; end
        end else if (est == s + 1) begin
          add_att(s, pid, din, len, off, 2, 0);
          eres = 1; stop = 1'b1;
        end else begin
          mv = (s == 1) ? tot - acc : 0;
          add_att(s, pid, din, len, off, 0, mv);
          acc += mv;
        end
      end
    end
    elen = (eres == 0) ? acc : 0;
  endtask

  task automatic wait_done();
    int w;
    w = 0;
    while (!done_o && w < 400) begin @(negedge clk); w++; end
  endtask

  task automatic run_case(input int hd, input int pin, input int tot, input int rs,
                          input int rd, input int rt, input int est, input bit disturb);
    int eres, elen, rhb, got;
    string tag;
    build(hd, pin, tot, rs, rd, rt, est, 3, eres, elen);
    @(negedge clk);
    base_idx    = n_rec;
    rhb         = n_rh;
    dev_addr_i  = 4'd5;
    root_addr_i = 4'd1;
    pipe_in_i   = pin[0];
    has_data_i  = hd[0];
    data_len_i  = LW'(tot);
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      @(negedge clk);
      pipe_in_i  = ~pin[0];
      has_data_i = ~hd[0];
      data_len_i = LW'(tot + 5);
      dev_addr_i = 4'd1;
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done();
    got = n_rec - base_idx;
    chk(got == n_exp, disturb ? "R9 attempt count" : "R4 attempt count", got, n_exp);
    for (int i = 0; i < n_exp && i < got; i++) begin
      tag = disturb ? "R9 attempt" : (exp_s[i] == 0) ? "R1 setup attempt" :
            (exp_s[i] == 1) ? "R2 data attempt" : "R3 status attempt";
      chk(rec_w[i] == exp_w[i], tag, rec_w[i], exp_w[i]);
    end
    tag = disturb ? "R9 result" : (eres == 2) ? "R5 timeout" : (eres == 1) ? "R6 error" : "R7 result";
    chk(done_o && int'(result_o) == eres, tag, int'(result_o), eres);
    chk(int'(act_len_o) == elen, disturb ? "R9 act_len" : "R7 act_len", int'(act_len_o), elen);
    chk(high_speed_o == 1'b0, "R8 bus not high speed", int'(high_speed_o), 0);
    chk(n_rh == rhb, "R8 bus bypasses root port", n_rh - rhb, 0);
    @(negedge clk);
    chk(!done_o, "R10 done pulse", int'(done_o), 0);
    chk(int'(result_o) == eres && int'(act_len_o) == elen, "R10 results held",
        int'(result_o), eres);
  endtask

  task automatic run_root(input bit err, input int len);
    int rb, eb;
    @(negedge clk);
    rh_err_cfg  = err;
    rh_len_cfg  = len;
    eb          = n_rec;
    rb          = n_rh;
    dev_addr_i  = 4'd3;
    root_addr_i = 4'd3;
    has_data_i  = 1'b1;
    data_len_i  = LW'(20);
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(done_o && int'(result_o) == (err ? 1 : 0), "R8 root result", int'(result_o), err ? 1 : 0);
    chk(int'(act_len_o) == (err ? 0 : len), "R8 root act_len", int'(act_len_o), err ? 0 : len);
    chk(high_speed_o == 1'b1, "R8 root high speed", int'(high_speed_o), 1);
    chk(n_rh - rb == 1, "R8 root port used once", n_rh - rb, 1);
    chk(n_rec == eb, "R8 no engine attempt", n_rec - eb, 0);
    @(negedge clk);
    chk(!done_o, "R10 done pulse root", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int lens [3];
    lens[0] = 1; lens[1] = 7; lens[2] = 40;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !eng_start_o && !rh_start_o, "R10 reset idle",
        int'({busy_o, done_o, eng_start_o, rh_start_o}), 0);
    chk(result_o == 2'd0 && act_len_o == '0 && !high_speed_o, "R10 reset results",
        int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !eng_start_o, "R9 idle after reset", int'(busy_o), 0);

    for (int pin = 0; pin < 2; pin++)
      for (int rs = 0; rs <= MT; rs++)
        for (int rt = 0; rt <= MT; rt++)
          run_case(0, pin, 12, rs, 0, rt, 0, 1'b0);

    for (int pin = 0; pin < 2; pin++)
      for (int li = 0; li < 3; li++)
        for (int rs = 0; rs <= MT; rs++)
          for (int rd = 0; rd <= MT; rd++)
            for (int rt = 0; rt <= MT; rt++)
              run_case(1, pin, lens[li], rs, rd, rt, 0, 1'b0);

    for (int hd = 0; hd < 2; hd++)
      for (int pin = 0; pin < 2; pin++)
        for (int est = 1; est <= 3; est++) begin
          if (hd == 0 && est == 2) continue;
          run_case(hd, pin, 25, 1, 1, 1, est, 1'b0);
          run_case(hd, pin, 25, 0, 0, 0, est, 1'b0);
        end

    run_case(1, 1, 30, 0, 2, 0, 0, 1'b1);
    run_case(0, 0, 30, 1, 0, 1, 0, 1'b1);
    run_case(1, 0, 9, 0, 1, 0, 0, 1'b1);

    run_root(1'b0, 18);
    run_root(1'b1, 18);
    run_case(1, 1, 10, 0, 0, 0, 0, 1'b0);
    run_root(1'b0, 4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule